// File: doc/BRIEF.md
# Haas Stereo Spreader

The block turns a mono sample stream into a left/right pair by delaying one side by a few milliseconds more than the other. The listener hears the image shift toward the earlier side. A single bipolar control code sets both the direction and the amount of the shift. Mid-scale gives a mono output. Moving the code away from mid-scale delays the opposite output in proportion to the distance.

Each input sample arrives with a one-cycle strobe at the 48 kHz audio rate. The block writes it into its own circular history buffer. On the same strobe it reads two past samples, one for each side, and registers them. The left and right results appear together on a single output-valid pulse one clock later. The delays depend only on the control code and on fixed parameters. No global delay bound and no sample-rate selection reaches the block.

Top module: `haas_spreader`

## Requirements
- R1: With `field_code` = 2048 (mid-scale), both outputs use the base delay of 14 samples, and `left_out` equals `right_out` on every valid pulse.
- R2: With `field_code` below 2048, `right_out` is delayed by 14 plus the added delay, and `left_out` by 14 samples only. The image moves left.
- R3: With `field_code` above 2048, `left_out` is delayed by 14 plus the added delay, and `right_out` by 14 samples only. The image moves right.
- R4: The added delay in samples is floor(|field_code − 2048| × 1440 / 2048), capped at 1440. Code 0 gives 1440 (30 ms). Code 4095 gives 1439. Codes 2047 and 2049 give 0.
- R5: A delay of d samples means that the output produced on strobe n is the input sample of strobe n − d, counting strobes from 0 after reset. `out_vld` is high for exactly the one cycle after each clock edge that has `smp_stb` high. Both outputs change together at that edge.
- R6: Without a strobe, no sample is stored, both outputs hold their values, and `out_vld` stays low. `smp_in` and `field_code` are used only in cycles where `smp_stb` is high.
- R7: An output whose delay reaches back before the first sample stored since reset reads 0.
- R8: While `rst_n` is low, `out_vld`, `left_out` and `right_out` are 0, and the stored history is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe per audio sample |
| smp_in | input | DATA_W (16) | Mono input sample |
| field_code | input | CTRL_W (12) | Stereo-field control, mid-scale 2048 |
| out_vld | output | 1 | Pulses one cycle after each strobe |
| left_out | output | DATA_W (16) | Left sample |
| right_out | output | DATA_W (16) | Right sample |

## Verification
Each result is due exactly one clock edge after the edge that takes the strobe. At that edge `out_vld` rises and both output samples load. Between strobes, nothing may change. The bench drives its inputs just after a rising edge. It forms the expected outputs for the following edge from a sample history it keeps itself. It moves those expectations into effect at that edge and compares them at the next falling edge, on every cycle. Inputs that change between strobes therefore have to leave the compared values unchanged. The stimulus covers the maximum added delay on both sides, the zero added delay on each side of mid-scale, and a reset that falls in the middle of a run.

// File: rtl/haas_pkg.sv
package haas_pkg;

   // which output carries the extra delay
   typedef enum logic [1:0] {
      SIDE_NONE  = 2'd0,
      SIDE_LEFT  = 2'd1,
      SIDE_RIGHT = 2'd2
   } side_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/haas_delay_map.sv
module haas_delay_map
   import haas_pkg::*;
#(
   parameter int CTRL_W   = 12,
   parameter int DLY_W    = 11,
   parameter int BASE_DLY = 14,
   parameter int MAX_ADD  = 1440
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] code,
   output logic [DLY_W-1:0]  dly_l,
   output logic [DLY_W-1:0]  dly_r
);
   localparam int ADD_W  = $clog2(MAX_ADD + 1);
   localparam int PROD_W = CTRL_W + ADD_W;
   localparam logic [CTRL_W-1:0] MID = {1'b1, {(CTRL_W-1){1'b0}}};

   logic [CTRL_W-1:0] dev;
   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] scaled;
   logic [ADD_W-1:0]  add;
   side_e             side;

   always_comb begin
      if (code > MID) begin
         dev  = code - MID;
         side = SIDE_LEFT;
      end else if (code < MID) begin
         dev  = MID - code;
         side = SIDE_RIGHT;
      end else begin
         dev  = '0;
         side = SIDE_NONE;
      end
   end

   // scaling variant picked by the span parameter
   generate
      if (is_pow2(MAX_ADD)) begin : g_shift
         assign prod = PROD_W'(dev) << $clog2(MAX_ADD);
      end else begin : g_mult
         assign prod = PROD_W'(dev) * PROD_W'(MAX_ADD);
      end
   endgenerate

   assign scaled = prod >> (CTRL_W - 1);
   assign add    = (scaled > PROD_W'(MAX_ADD)) ? ADD_W'(MAX_ADD) : scaled[ADD_W-1:0];

   always_comb begin
      dly_l = DLY_W'(BASE_DLY);
      dly_r = DLY_W'(BASE_DLY);
      unique case (side)
         SIDE_LEFT:  dly_l = DLY_W'(BASE_DLY) + DLY_W'(add);
         SIDE_RIGHT: dly_r = DLY_W'(BASE_DLY) + DLY_W'(add);
         default: ;
      endcase
   end

   // R4
   dly_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_l >= DLY_W'(BASE_DLY)) && (dly_l <= DLY_W'(BASE_DLY + MAX_ADD)) &&
      (dly_r >= DLY_W'(BASE_DLY)) && (dly_r <= DLY_W'(BASE_DLY + MAX_ADD)));

   // R2
   right_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code < MID) |-> (dly_l == DLY_W'(BASE_DLY)));

   // R3
   left_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code > MID) |-> (dly_r == DLY_W'(BASE_DLY)));

   // R1
   centre_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code == MID) |-> (dly_l == dly_r));

endmodule

// File: rtl/haas_ring_buf.sv
module haas_ring_buf #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 2048,
   parameter int N_RD   = 2,
   parameter int DLY_W  = 11
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [N_RD-1:0][DLY_W-1:0]   rd_dly,
   output logic [N_RD-1:0][DATA_W-1:0]  rd_data
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW-1:0] FILL_SAT = AW'(DEPTH - 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr;
   logic [AW-1:0]     fill;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         fill   <= '0;
      end else if (wr_en) begin
         wr_ptr <= wr_ptr + 1'b1;
         if (fill != FILL_SAT) fill <= fill + 1'b1;
      end
   end

   generate
      for (genvar p = 0; p < N_RD; p++) begin : g_rd
         logic [AW-1:0] rd_addr;
         logic          have;
         assign rd_addr = wr_ptr - AW'(rd_dly[p]);
         assign have    = AW'(rd_dly[p]) <= fill;
         assign rd_data[p] = have ? mem[rd_addr] : '0;
      end
   endgenerate

   // R6
   ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(wr_ptr) && $stable(fill));

endmodule

// File: rtl/haas_spreader.sv
module haas_spreader #(
   parameter int DATA_W   = 16,
   parameter int CTRL_W   = 12,
   parameter int BASE_DLY = 14,
   parameter int MAX_ADD  = 1440,
   parameter int DEPTH    = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_stb,
   input  logic [DATA_W-1:0] smp_in,
   input  logic [CTRL_W-1:0] field_code,
   output logic              out_vld,
   output logic [DATA_W-1:0] left_out,
   output logic [DATA_W-1:0] right_out
);
   import haas_pkg::*;

   localparam int DLY_W = $clog2(DEPTH);
   localparam logic [CTRL_W-1:0] MID = {1'b1, {(CTRL_W-1){1'b0}}};

   // elaboration-time parameter checks
   generate
      if (!is_pow2(DEPTH)) begin : g_bad_depth
         initial $fatal(1, "DEPTH must be a power of two");
      end
      if (DEPTH <= BASE_DLY + MAX_ADD) begin : g_bad_room
         initial $fatal(1, "DEPTH too small for the longest delay");
      end
      if (BASE_DLY < 1) begin : g_bad_base
         initial $fatal(1, "BASE_DLY must be at least one sample");
      end
      if (CTRL_W < 2 || DATA_W < 1) begin : g_bad_width
         initial $fatal(1, "bad width parameter");
      end
   endgenerate

   logic [DLY_W-1:0]            dly_l, dly_r;
   logic [1:0][DLY_W-1:0]       rd_dly;
   logic [1:0][DATA_W-1:0]      rd_data;

   haas_delay_map #(
      .CTRL_W(CTRL_W), .DLY_W(DLY_W), .BASE_DLY(BASE_DLY), .MAX_ADD(MAX_ADD)
   ) map_i (
      .clk(clk), .rst_n(rst_n), .code(field_code), .dly_l(dly_l), .dly_r(dly_r)
   );

   assign rd_dly[0] = dly_l;
   assign rd_dly[1] = dly_r;

   haas_ring_buf #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .N_RD(2), .DLY_W(DLY_W)
   ) buf_i (
      .clk(clk), .rst_n(rst_n), .wr_en(smp_stb), .wr_data(smp_in),
      .rd_dly(rd_dly), .rd_data(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld   <= 1'b0;
         left_out  <= '0;
         right_out <= '0;
      end else begin
         out_vld <= smp_stb;
         if (smp_stb) begin
            left_out  <= rd_data[0];
            right_out <= rd_data[1];
         end
      end
   end

   // R5
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> out_vld);

   // R5
   no_spur_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> !out_vld);

   // R6
   hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> $stable(left_out) && $stable(right_out));

   // R1
   mono_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && field_code == MID) |=> (left_out == right_out));

endmodule

// File: tb/haas_spreader_tb.sv
`timescale 1ns/1ps
module haas_spreader_tb_top;
   localparam int BASE = 14;
   localparam int SPAN = 1440;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_stb = 1'b0;
   logic [15:0] smp_in = '0;
   logic [11:0] field_code = 12'd2048;
   logic        out_vld;
   logic [15:0] left_out, right_out;

   always #2.5 clk = ~clk;

   haas_spreader dut_i (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_in(smp_in),
      .field_code(field_code), .out_vld(out_vld),
      .left_out(left_out), .right_out(right_out)
   );

   int n_vec = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 0;
   bit chk_on = 0;
   string tag = "R8";

   logic [15:0] hist[$];
   logic        nxt_vld = 0, cur_vld = 0;
   logic [15:0] nxt_l = 0, nxt_r = 0, cur_l = 0, cur_r = 0;

   always @(posedge clk) begin
      cur_vld <= nxt_vld;
      cur_l   <= nxt_l;
      cur_r   <= nxt_r;
   end

   function automatic int add_of(input int code);
      int dev = (code >= 2048) ? code - 2048 : 2048 - code;
      int a = dev * SPAN / 2048;
      return (a > SPAN) ? SPAN : a;
   endfunction

   task automatic report(input string what, input logic [15:0] act, input logic [15:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && chk_on && !done) begin
         report("out_vld", {15'd0, out_vld}, {15'd0, cur_vld});
         report("left_out", left_out, cur_l);
         report("right_out", right_out, cur_r);
      end
   end

   // one cycle of stimulus, and the model's view of the next edge
   task automatic step(input bit stb, input logic [15:0] d, input logic [11:0] c);
      @(posedge clk); #1;
      smp_stb = stb; smp_in = d; field_code = c;
      nxt_vld = stb;
      if (stb) begin
         int n = hist.size();
         int add = add_of(int'(c));
         int dl = BASE + ((c > 12'd2048) ? add : 0);
         int dr = BASE + ((c < 12'd2048) ? add : 0);
         hist.push_back(d);
         nxt_l = (n >= dl) ? hist[n - dl] : 16'd0;
         nxt_r = (n >= dr) ? hist[n - dr] : 16'd0;
      end
   endtask

   // three cycles per sample; input and code wander off-strobe (R6)
   task automatic run(input int count, input int code);
      for (int i = 0; i < count; i++) begin
         step(1'b1, 16'($urandom), 12'(code));
         step(1'b0, 16'($urandom), 12'($urandom));
         step(1'b0, 16'($urandom), 12'($urandom));
      end
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 0; smp_stb = 0;
      hist.delete();
      nxt_vld = 0; nxt_l = 0; nxt_r = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      tag = "R8";
      report("reset out_vld", {15'd0, out_vld}, 16'd0);
      report("reset left_out", left_out, 16'd0);
      report("reset right_out", right_out, 16'd0);
      @(posedge clk); #1;
      rst_n = 1;
   endtask

   initial begin
      do_reset();
      chk_on = 1;
      tag = "R1"; run(200, 2048);          // first 14 outputs read empty history (R7)
      tag = "R2"; run(1600, 0);            // R4 longest span 1440 on right
      tag = "R3"; run(1600, 4095);         // R4 span 1439 on left
      tag = "R2"; run(900, 1024);          // added 720
      tag = "R3"; run(800, 3000);          // added 669
      tag = "R6";
      for (int i = 0; i < 1500; i++) run(1, int'($urandom_range(0, 4095)));
      chk_on = 0;
      do_reset();                          // R8 mid-run
      chk_on = 1;
      tag = "R7"; run(100, 0);             // history gone: right stays 0
      tag = "R4"; run(100, 2049);
      run(100, 2047);
      tag = "R5"; run(1500, 1);
      step(1'b0, 16'h1234, 12'd0);
      repeat (4) step(1'b0, 16'($urandom), 12'($urandom));
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog: actual cycle %0d expected finish before 150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule